// File: doc/BRIEF.md
# Interpolating Sine Phase-to-Amplitude Converter

This block turns a phase word from a phase accumulator into a signed sine sample. The upper phase bits select a point in a constant table that holds one full sine period. The next lower bits give the position between that point and the next one. The block reads both neighbouring entries in the same cycle and blends them in a straight line. For a given table size, this gives a smaller phase error than a plain truncated lookup.

Each sample travels through a three-stage pipeline: table read, then difference and multiply, then round and add. A valid flag travels with the data. An optional second lane gives a cosine sample. It uses the same datapath with the phase moved forward by a quarter turn, so both outputs come from one input word in the same cycle. The table is built at elaboration from the parameters, and nothing needs to load it.

Top module: `nco_interp_pac`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly three clock cycles.
- R2: While `rst` is high, `out_valid` is 0 on the next cycle, and `sin_out` and `cos_out` are 0.
- R3: When the fraction field (phase bits [FRAC_W-1:0]) is zero, `sin_out` equals entry a exactly. Here a = phase[PHASE_W-1:FRAC_W], and entry(i) = round(A·sin(2πi/2^ADDR_W)), with A = 2^(AMP_W-1)-1 and halves rounded up.
- R4: For any phase, `sin_out` = e(a) + floor(((e(a+1) - e(a))·f + 2^(FRAC_W-1)) / 2^FRAC_W), where f is the fraction field read as unsigned.
- R5: At the top address a = 2^ADDR_W-1, the second entry used is entry 0. The blend therefore wraps across the end of the period.
- R6: Accuracy:
  - `sin_out` stays within 1 + A·(2π/2^ADDR_W)²/8 of the real value A·sin(2π·phase/2^PHASE_W).
  - `sin_out` never equals -2^(AMP_W-1).
- R7: With WITH_COS = 1, `cos_out` equals the R4 result for the phase (phase + 2^(PHASE_W-2)) mod 2^PHASE_W, in the same cycle as `sin_out`.
- R8: In any cycle where `out_valid` is 0, `sin_out` and `cos_out` keep their previous values. This holds for bubbles in the input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Phase word valid |
| phase_in | input | ADDR_W+FRAC_W | Phase word: top ADDR_W bits select the address, low FRAC_W bits give the weight |
| out_valid | output | 1 | Sample valid, three cycles after input |
| sin_out | output | AMP_W | Signed sine sample |
| cos_out | output | AMP_W | Signed cosine sample (0 when WITH_COS = 0) |

## Verification
Phases with a zero fraction show whether the table itself is right, apart from any blending. Chosen fractions of 1, 128 and 255 test the rounding of the product. Phases at the top address with several fractions tell a correct wrap to entry 0 from a read past the end of the table. A long pseudo-random sweep compares every sample with an exact integer model and with a real-valued sine inside the interpolation bound. Streams with bubbles tell correct valid tracking and output holding apart from data that drifts when no sample arrives.

// File: rtl/nco_pac_pkg.sv
package nco_pac_pkg;
    localparam real TWO_PI = 6.283185307179586;

    function automatic int unsigned amp_max(input int unsigned amp_w);
        return (1 << (amp_w - 1)) - 1;
    endfunction
endpackage

// File: rtl/sine_rom.sv
module sine_rom #(
    parameter int ADDR_W = 8,
    parameter int AMP_W  = 16
) (
    input  logic [ADDR_W-1:0]       addr,
    output logic signed [AMP_W-1:0] data
);
    import nco_pac_pkg::*;

    localparam int  DEPTH = 1 << ADDR_W;
    localparam real AMPR  = real'(amp_max(AMP_W));

    logic signed [AMP_W-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam int VAL = $rtoi($floor(AMPR * $sin(TWO_PI * real'(i) / real'(DEPTH)) + 0.5));
        assign tbl[i] = AMP_W'(VAL);
    end

    assign data = tbl[addr];
endmodule

// File: rtl/interp_lane.sv
module interp_lane #(
    parameter int ADDR_W = 8,
    parameter int FRAC_W = 8,
    parameter int AMP_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [ADDR_W+FRAC_W-1:0]   phase,
    output logic                       out_valid,
    output logic signed [AMP_W-1:0]    sample
);
    localparam int PHASE_W = ADDR_W + FRAC_W;
    localparam int DIFF_W  = AMP_W + 1;
    localparam int PROD_W  = AMP_W + FRAC_W + 2;
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC_W - 1);

    typedef struct packed {
        logic                       v1;
        logic signed [AMP_W-1:0]    lo1;
        logic signed [AMP_W-1:0]    hi1;
        logic [FRAC_W-1:0]          wt1;
        logic                       v2;
        logic signed [AMP_W-1:0]    lo2;
        logic signed [PROD_W-1:0]   prod2;
        logic                       v3;
        logic signed [AMP_W-1:0]    y3;
    } lane_st_t;

    lane_st_t st_d, st_q;

    logic [ADDR_W-1:0]       adr_lo, adr_hi;
    logic signed [AMP_W-1:0] rd_lo, rd_hi;
    logic signed [DIFF_W-1:0] diff;
    logic signed [FRAC_W:0]  wt_s;

    assign adr_lo = phase[PHASE_W-1:FRAC_W];
    assign adr_hi = adr_lo + ADDR_W'(1);

    sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom_lo (.addr(adr_lo), .data(rd_lo));
    sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom_hi (.addr(adr_hi), .data(rd_hi));

    always_comb begin
        st_d  = st_q;
        diff  = DIFF_W'($signed(st_q.hi1)) - DIFF_W'($signed(st_q.lo1));
        wt_s  = $signed({1'b0, st_q.wt1});

        st_d.v1 = in_valid;
        if (in_valid) begin
            st_d.lo1 = rd_lo;
            st_d.hi1 = rd_hi;
            st_d.wt1 = phase[FRAC_W-1:0];
        end

        st_d.v2 = st_q.v1;
        if (st_q.v1) begin
            st_d.lo2   = st_q.lo1;
            st_d.prod2 = PROD_W'(diff) * PROD_W'(wt_s);
        end

        st_d.v3 = st_q.v2;
        if (st_q.v2) begin
            st_d.y3 = AMP_W'((($signed(st_q.prod2) + HALF) >>> FRAC_W)
                             + PROD_W'($signed(st_q.lo2)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.v3;
    assign sample    = st_q.y3;
endmodule

// File: rtl/nco_interp_pac.sv
module nco_interp_pac #(
    parameter int ADDR_W   = 8,
    parameter int FRAC_W   = 8,
    parameter int AMP_W    = 16,
    parameter bit WITH_COS = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [ADDR_W+FRAC_W-1:0]  phase_in,
    output logic                      out_valid,
    output logic signed [AMP_W-1:0]   sin_out,
    output logic signed [AMP_W-1:0]   cos_out
);
    localparam int PHASE_W = ADDR_W + FRAC_W;
    localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(1) << (PHASE_W - 2);

    logic sin_v;

    interp_lane #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .AMP_W(AMP_W)) u_sin (
        .clk(clk), .rst(rst), .in_valid(in_valid), .phase(phase_in),
        .out_valid(sin_v), .sample(sin_out)
    );

    if (WITH_COS) begin : g_cos
        logic                   cos_v;
        logic [PHASE_W-1:0]     cos_phase;
        assign cos_phase = phase_in + QUARTER;

        interp_lane #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .AMP_W(AMP_W)) u_cos (
            .clk(clk), .rst(rst), .in_valid(in_valid), .phase(cos_phase),
            .out_valid(cos_v), .sample(cos_out)
        );
        assign out_valid = sin_v & cos_v;
    end else begin : g_nocos
        assign cos_out   = '0;
        assign out_valid = sin_v;
    end
endmodule

// File: rtl/nco_interp_pac_chk.sv
module nco_interp_pac_chk #(
    parameter int AMP_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     out_valid,
    input logic signed [AMP_W-1:0]  sin_out,
    input logic signed [AMP_W-1:0]  cos_out
);
    localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R1

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && sin_out == '0 && cos_out == '0)); // R2

    AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (sin_out != MOST_NEG && cos_out != MOST_NEG)); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(sin_out) && $stable(cos_out))); // R8
endmodule

bind nco_interp_pac nco_interp_pac_chk #(.AMP_W(AMP_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .sin_out(sin_out), .cos_out(cos_out)
);

// File: tb/tb_nco_interp_pac.sv
module tb_nco_interp_pac;
    localparam int  ADDR_W  = 8;
    localparam int  FRAC_W  = 8;
    localparam int  AMP_W   = 16;
    localparam int  PHASE_W = ADDR_W + FRAC_W;
    localparam int  DEPTH   = 1 << ADDR_W;
    localparam int  AMP     = (1 << (AMP_W - 1)) - 1;
    localparam real TWO_PI  = 6.283185307179586;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     in_valid = 1'b0;
    logic [PHASE_W-1:0]       phase_in = '0;
    logic                     out_valid;
    logic signed [AMP_W-1:0]  sin_out, cos_out;

    nco_interp_pac #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .AMP_W(AMP_W), .WITH_COS(1'b1)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .phase_in(phase_in),
        .out_valid(out_valid), .sin_out(sin_out), .cos_out(cos_out)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    ph;
        int    cyc;
        string tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit seen = 1'b0;
    int last_sin = 0, last_cos = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int entry(input int i);
        return $rtoi($floor(real'(AMP) * $sin(TWO_PI * real'(i) / real'(DEPTH)) + 0.5));
    endfunction

    function automatic int model(input int ph);
        int a, f, y0, y1;
        a  = (ph >> FRAC_W) % DEPTH;
        f  = ph % (1 << FRAC_W);
        y0 = entry(a);
        y1 = entry((a + 1) % DEPTH);
        return y0 + (((y1 - y0) * f + (1 << (FRAC_W - 1))) >>> FRAC_W);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int ph, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        phase_in = PHASE_W'(ph);
        it.ph = ph % (1 << PHASE_W);
        it.cyc = cyc;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            phase_in = PHASE_W'(k * 37);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R1", 1, 0);
                end else begin
                    item_t it;
                    int es, ec, cph;
                    real ideal, tol;
                    it  = q.pop_front();
                    es  = model(it.ph);
                    cph = (it.ph + (1 << (PHASE_W - 2))) % (1 << PHASE_W);
                    ec  = model(cph);
                    check(cyc - it.cyc == 3, "R1", cyc - it.cyc, 3);
                    check(int'(sin_out) == es, it.tag, int'(sin_out), es);
                    check(int'(cos_out) == ec, "R7", int'(cos_out), ec);
                    ideal = real'(AMP) * $sin(TWO_PI * real'(it.ph) / real'(1 << PHASE_W));
                    tol   = 1.0 + real'(AMP) * (TWO_PI / DEPTH) * (TWO_PI / DEPTH) / 8.0;
                    check((real'(sin_out) - ideal <= tol) && (ideal - real'(sin_out) <= tol),
                          "R6", int'(sin_out), $rtoi(ideal));
                end
                last_sin = int'(sin_out);
                last_cos = int'(cos_out);
                seen = 1'b1;
            end else if (seen) begin
                check(int'(sin_out) == last_sin && int'(cos_out) == last_cos,
                      "R8", int'(sin_out), last_sin);
            end
        end
    end

    // watchdog
    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int lcg;
        int waitn;
        repeat (3) @(negedge clk);
        // R2: outputs cleared during reset
        check(out_valid == 1'b0, "R2", int'(out_valid), 0);
        check(sin_out == '0 && cos_out == '0, "R2", int'(sin_out), 0);
        @(negedge clk);
        rst = 1'b0;

        // R3: zero fraction returns table entries
        send(0, "R3");
        send(64 << FRAC_W, "R3");
        send(128 << FRAC_W, "R3");
        send(192 << FRAC_W, "R3");
        send(33 << FRAC_W, "R3");
        idle(2);

        // R4: rounding of the blend
        send((10 << FRAC_W) | 128, "R4");
        send((70 << FRAC_W) | 1, "R4");
        send((130 << FRAC_W) | 255, "R4");
        send((200 << FRAC_W) | 77, "R4");
        send((100 << FRAC_W) | 200, "R4");

        // R5: wrap at top address
        send((255 << FRAC_W) | 64, "R5");
        send((255 << FRAC_W) | 128, "R5");
        send((255 << FRAC_W) | 255, "R5");
        send((255 << FRAC_W), "R5");

        // R8: bubbles between samples
        idle(3);
        send((40 << FRAC_W) | 9, "R8");
        idle(1);
        send((41 << FRAC_W) | 250, "R8");
        idle(4);

        // R4 sweep with pseudo-random phases
        lcg = 12345;
        for (int k = 0; k < 400; k++) begin
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            send((lcg >> 8) & ((1 << PHASE_W) - 1), "R4");
            if (k % 53 == 0) idle(2);
        end
        idle(6);

        waitn = 0;
        while (q.size() != 0 && waitn < 50) begin
            @(negedge clk);
            waitn++;
        end
        check(q.size() == 0, "R1", q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule